// File: doc/BRIEF.md
# Dual-Reload PWM Timer Channel

A single timer channel that generates a toggling output from a down-counter. Two reload registers set the width of the output's low phase and its high phase. When dual-phase mode is on, the counter reloads from these two registers in turn, so the waveform can be asymmetric. When dual-phase mode is off, only the low-phase register is used, and the result is a square wave with equal halves. When reload mode is clear, the counter runs freely and wraps from zero to all ones.

Software programs the channel through a simple synchronous port. A write is taken on the clock edge and a read is combinational. Enabling the channel loads the low-phase value and starts the output in the low phase. Clearing the enable bit freezes the counter and forces the output low at that same edge.

Top module: `pwm_dual_timer`

## Requirements
- R1: Enabling the channel (ctrl bit 0 going from 0 to 1) loads the low-phase register value L, as held before that edge, into the counter. The output is then low for exactly L+1 clock cycles, counted from the enabling edge.
- R2: With reload mode set (ctrl bit 1) and dual-phase mode set (ctrl bit 2), each low phase lasts L+1 cycles and each high phase lasts H+1 cycles, where H is the high-phase register. The two phases alternate.
- R3: With reload mode set and dual-phase mode clear, the output toggles every L+1 cycles. The high-phase register has no effect on the output in this mode.
- R4: With reload mode clear, the first low phase lasts L+1 cycles. After it, the counter wraps to all ones at each expiry, so every following phase lasts 2^CNT_W cycles.
- R5: A write that clears the enable bit stops the counter at that edge and drives the output low from that edge on. The counter holds and the output stays low while the channel is disabled.
- R6: A new low-phase or high-phase value written while the channel runs is used at the next reload that selects that register.
- R7: Register map, selected by addr_i: 0 = control (bit 0 run, bit 1 reload mode, bit 2 dual-phase, all other bits read 0), 1 = low-phase reload, 2 = high-phase reload, 3 = reads 0. Every register reads back its last written value. After reset all registers read 0 and the output is low.
- R8: A write is visible on rdata_o in the cycle after its clock edge, and only writes with wr_en_i high change a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register select for both write and read |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Combinational read data for addr_i |
| pwm_o | output | 1 | Timer output |

## Verification
The bench drives inputs at falling edges, so every result it checks falls due at a known rising edge.

- **Enable write (edge E0):** the output is low in the sample right after E0. The first rising output shows up L+2 samples after E0.
- **Disable write:** the output must already be low at the next sample.
- **Readback:** it is combinational, so it is checked one sample after the write edge.

For each configuration, the output at each falling-edge sample k is compared with a value worked out from L, H and the mode. The comparison covers at least two full periods, and for wrap mode it covers two full wrap periods.

// File: rtl/pwm_dual_timer_pkg.sv
package pwm_dual_timer_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LO   = 2'd1,
    REG_HI   = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic dual;    // bit 2: alternate low/high reload values
    logic reload;  // bit 1: reload from registers, else wrap to all ones
    logic run;     // bit 0: channel enable
  } ctrl_t;

  localparam int CTRL_W = 3;
endpackage

// File: rtl/pwm_dual_timer_regs.sv
module pwm_dual_timer_regs
  import pwm_dual_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output ctrl_t            ctrl_o,
  output ctrl_t            ctrl_nxt_o,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] hi_o,
  output logic [CNT_W-1:0] rdata_o
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] lo_q, hi_q;
  reg_sel_e         sel;

  assign sel = reg_sel_e'(addr_i);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i && sel == REG_CTRL) ctrl_d = ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_en_i && sel == REG_LO) lo_q <= wdata_i;
      if (wr_en_i && sel == REG_HI) hi_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      REG_CTRL: rdata_o[CTRL_W-1:0] = ctrl_q;
      REG_LO:   rdata_o = lo_q;
      REG_HI:   rdata_o = hi_q;
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign ctrl_nxt_o = ctrl_d;
  assign lo_o       = lo_q;
  assign hi_o       = hi_q;
endmodule

// File: rtl/pwm_dual_timer_core.sv
module pwm_dual_timer_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_nxt_i,
  input  logic             reload_i,
  input  logic             dual_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             phase_o,
  output logic             armed_o
);
  logic [CNT_W-1:0] cnt_q, reload_val;
  logic             phase_q, armed_q, expire;

  assign expire = (cnt_q == '0);

  // value taken at expiry; phase_q = 0 means the low phase is ending
  always_comb begin
    if (!reload_i)                 reload_val = '1;
    else if (dual_i && !phase_q)   reload_val = hi_i;
    else                           reload_val = lo_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      armed_q <= 1'b0;
    end else if (!run_nxt_i) begin
      // stop at the edge of the disabling write; counter holds
      armed_q <= 1'b0;
      phase_q <= 1'b0;
    end else if (!armed_q) begin
      cnt_q   <= lo_i;
      phase_q <= 1'b0;
      armed_q <= 1'b1;
    end else if (expire) begin
      cnt_q   <= reload_val;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign phase_o = phase_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer
  import pwm_dual_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             pwm_o
);
  ctrl_t            ctrl_q, ctrl_nxt;
  logic [CNT_W-1:0] lo_q, hi_q, cnt_q;
  logic             phase_q, armed_q;

  pwm_dual_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .ctrl_o     (ctrl_q),
    .ctrl_nxt_o (ctrl_nxt),
    .lo_o       (lo_q),
    .hi_o       (hi_q),
    .rdata_o    (rdata_o)
  );

  pwm_dual_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_nxt_i (ctrl_nxt.run),
    .reload_i  (ctrl_q.reload),
    .dual_i    (ctrl_q.dual),
    .lo_i      (lo_q),
    .hi_i      (hi_q),
    .cnt_o     (cnt_q),
    .phase_o   (phase_q),
    .armed_o   (armed_q)
  );

  assign pwm_o = phase_q;
endmodule

// File: rtl/pwm_dual_timer_chk.sv
module pwm_dual_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pwm_o,
  input logic             en_q,
  input logic             en_nxt,
  input logic             reload_q,
  input logic             dual_q,
  input logic [CNT_W-1:0] lo_q,
  input logic [CNT_W-1:0] hi_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             armed_q
);
  // R5
  off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !pwm_o);

  // R5
  off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_nxt |=> (cnt_q == $past(cnt_q)) && !pwm_o);

  // R1
  arm_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_nxt && !armed_q) |=> (cnt_q == $past(lo_q)) && !pwm_o);

  // R1
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_nxt && armed_q && cnt_q != '0) |=>
      (cnt_q == CNT_W'($past(cnt_q) - 1'b1)) && $stable(pwm_o));

  // R2
  hi_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_nxt && armed_q && cnt_q == '0 && reload_q && dual_q && !pwm_o) |=>
      (cnt_q == $past(hi_q)) && pwm_o);

  // R3
  square_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_nxt && armed_q && cnt_q == '0 && reload_q && !dual_q) |=>
      (cnt_q == $past(lo_q)) && (pwm_o != $past(pwm_o)));

  // R4
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_nxt && armed_q && cnt_q == '0 && !reload_q) |=>
      (&cnt_q) && (pwm_o != $past(pwm_o)));
endmodule

bind pwm_dual_timer pwm_dual_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pwm_o    (pwm_o),
  .en_q     (ctrl_q.run),
  .en_nxt   (ctrl_nxt.run),
  .reload_q (ctrl_q.reload),
  .dual_q   (ctrl_q.dual),
  .lo_q     (lo_q),
  .hi_q     (hi_q),
  .cnt_q    (cnt_q),
  .armed_q  (armed_q)
);

// File: tb/pwm_dual_timer_bench.sv
module pwm_dual_timer_bench;
  localparam int W    = 8;
  localparam int WRAP = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         pwm;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwm_dual_timer #(.CNT_W(W)) u_pwm_dual_timer (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .pwm_o   (pwm)
  );

  // called at a falling edge, returns at the next falling edge
  task automatic wr(input int a, input int d);
    wr_en = 1'b1;
    addr  = a[1:0];
    wdata = d[W-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input int a, input int exp);
    addr = a[1:0];
    #1;
    chk(tag, int'(rdata), exp);
  endtask

  // mode 0: dual-phase, 1: square, 2: wrap; t counts cycles from the enabling edge
  function automatic bit exp_out(input int mode, input int l, input int h, input int t);
    if (mode == 0) return (t % (l + h + 2)) >= l + 1;
    if (mode == 1) return (t % (2 * (l + 1))) >= l + 1;
    if (t < l + 1) return 1'b0;
    return ((t - (l + 1)) / WRAP) % 2 == 0;
  endfunction

  task automatic run_cfg(input string tag, input int l, input int h,
                         input int mode, input int n);
    int bad = 0;
    int first_k = 0;
    bit first_a = 0, first_e = 0;
    int ctrl = (mode == 0) ? 7 : (mode == 1) ? 3 : 1;
    wr(0, 0);
    wr(1, l);
    wr(2, h);
    wr(0, ctrl);
    for (int k = 1; k <= n; k++) begin
      if (pwm !== exp_out(mode, l, h, k - 1)) begin
        if (bad == 0) begin
          first_k = k; first_a = pwm; first_e = exp_out(mode, l, h, k - 1);
        end
        bad++;
      end
      @(negedge clk);
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: l=%0d h=%0d sample %0d actual=%b expected=%b",
               tag, l, h, first_k, first_a, first_e);
    end
    // R5: disable forces low at once and keeps it low
    wr(0, 0);
    chk("R5 low after disable", int'(pwm), 0);
    repeat (3) @(negedge clk);
    chk("R5 low while disabled", int'(pwm), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int vals[7] = '{0, 1, 2, 3, 7, 30, 255};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 reset state
    chk("R7 reset out", int'(pwm), 0);
    rd_chk("R7 reset ctrl", 0, 0);
    rd_chk("R7 reset lo", 1, 0);
    rd_chk("R7 reset hi", 2, 0);

    // R7 / R8 readback, upper ctrl bits dropped, run bit clear keeps output low
    wr(0, 'hFE);
    rd_chk("R7 ctrl readback", 0, 6);
    chk("R7 output low when not run", int'(pwm), 0);
    wr(1, 'hA5);
    rd_chk("R8 lo visible after edge", 1, 'hA5);
    wr(2, 'h3C);
    rd_chk("R7 hi readback", 2, 'h3C);
    rd_chk("R7 addr3 zero", 3, 0);
    addr = 2'd1; wdata = 8'h11; #1; // wr_en low: no change
    @(negedge clk);
    rd_chk("R8 no write without strobe", 1, 'hA5);

    // R1 R2: dual-phase sweep
    foreach (vals[i]) foreach (vals[j])
      run_cfg("R1 R2 dual-phase", vals[i], vals[j], 0,
              2 * (vals[i] + vals[j] + 2) + 3);

    // R3: square wave, high register varied and ignored
    foreach (vals[i]) begin
      run_cfg("R3 square", vals[i], 200, 1, 4 * (vals[i] + 1) + 3);
      run_cfg("R3 square hi ignored", vals[i], 0, 1, 4 * (vals[i] + 1) + 3);
    end

    // R4: wrap mode
    run_cfg("R4 wrap", 3, 9, 2, 4 + 2 * WRAP + 5);
    run_cfg("R4 wrap", 0, 0, 2, 1 + 2 * WRAP + 5);

    // R6: high value updated during first low phase
    begin
      int bad = 0;
      wr(0, 0); wr(1, 5); wr(2, 5); wr(0, 7);
      for (int k = 1; k <= 60; k++) begin
        if (pwm !== exp_out(0, 5, 20, k - 1)) bad++;
        if (k == 2) wr(2, 20);
        else @(negedge clk);
      end
      chk("R6 running update of high value", bad, 0);
      wr(0, 0);
    end

    // R1: re-enable after disable restarts low with full low phase
    run_cfg("R1 restart", 4, 2, 0, 20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule